// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects a linear set of peripheral interrupt requests. Each request is caught in a per-source flag bit and gated by a per-source enable bit. Each source also has a 5-bit priority, built from a 3-bit major part and a 2-bit sub part. Combinational arbitration picks the highest-priority source that is pending, enabled and has a non-zero priority. It drives a single interrupt line to the processor and reports the winner's number in a read-only status register.

Sources come in three kinds. Level (persistent) sources keep re-arming their flag while the peripheral holds its request. Edge (non-persistent) sources latch a flag on a rising request and keep it until software clears it. A few external pin sources use edge detection, and a control register selects the edge for each pin. Every bank register can be reached at three word addresses: a plain write, a write-ones-to-clear alias and a write-ones-to-set alias. Software can therefore change single bits without a read-modify-write. Each source also owns a 32-bit vector offset word that software can read and write.

Top module: `prio_intc`

## Requirements
- R1: After reset, all flags, all enables and the control register read 0. Every priority field reads 8 (major 2, sub 0). The status register reads 0 and irqOut is low.
- R2: Source n sits at bit n%32 of word n/32 in two banks: the flag bank at 0x040 + 0x10*(n/32) and the enable bank at 0x0C0 + 0x10*(n/32). Bits for sources that do not exist read 0.
- R3: For the control, flag, enable and priority registers, the address offsets within a register work as follows. Offset +0x0 writes the value. Offset +0x4 clears the bits written as 1. Offset +0x8 sets the bits written as 1. All other bits are unchanged, and a read at any of the three offsets returns the register.
- R4: The priority of source n is in word 0x140 + 0x10*(n/4), bits (n%4)*8 to (n%4)*8+4, encoded as major*4+sub. Bits 5 to 7 of each 8-bit lane read 0.
- R5: The status register at 0x020 gives the winning source number in bits 7:0 and sets bit 8 when any source qualifies. A source qualifies when its flag and enable are both set and its priority is non-zero. The winner is the qualifying source with the largest priority. Writes to the status register have no effect.
- R6: When two qualifying sources have equal priority, the lower source number wins.
- R7: irqOut is high exactly when some source qualifies. A priority of 0 keeps a source from qualifying.
- R8: An edge source sets its flag in the cycle after its request rises, and the flag holds until software clears it. Clearing the flag while the request stays high leaves it clear.
- R9: A level source sets its flag in every cycle its request is high, so a software clear has no lasting effect until the request drops. A hardware set wins over a clear in the same cycle.
- R10: External pin e drives source EXT_BASE+e. Control bit e set to 1 selects rising-edge detection, and 0 selects falling-edge detection. The request input of such a source is ignored.
- R11: The vector offset word of source n, at 0x540 + 4*n, is a 32-bit register that software can read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| srcReq | input | NUM_SRC | Peripheral interrupt requests |
| extPin | input | NUM_EXT | External interrupt pins |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions check four things on every cycle. Hardware request conditions must set the flag one cycle later: a level request, a rising edge request and an external edge of the selected polarity. The reported winner must qualify. No qualifying source may beat the winner on priority or, at equal priority, on source number. irqOut must be high whenever any source qualifies. Other behaviours can only be shown by the bench's scenarios: the alias address decoding, the field layout, the reset values, a persistent flag surviving a clear, an edge flag staying clear under a held request, and the blocking of wrong-polarity edges and of the request input on pin sources.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int BUS_W  = 32;
  localparam int MAJ_W  = 3;
  localparam int SUB_W  = 2;
  localparam int PRI_W  = MAJ_W + SUB_W;
  localparam int LANE_W = 8;
  localparam int IDX_W  = 8;

  // default priority: major 2, sub 0
  localparam logic [PRI_W-1:0] DEF_PRI = {3'd2, 2'd0};

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_NONE  = 2'd3
  } wrOp_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_FLAG,
    SEL_EN,
    SEL_PRI,
    SEL_VEC
  } regSel_e;

  typedef struct packed {
    regSel_e          sel;
    wrOp_e            op;
    logic [IDX_W-1:0] idx;
    logic             wrEn;
  } regStrobe_t;

  function automatic logic [BUS_W-1:0] applyOp(wrOp_e op, logic [BUS_W-1:0] cur,
                                               logic [BUS_W-1:0] val);
    case (op)
      OP_PLAIN: applyOp = val;
      OP_CLR:   applyOp = cur & ~val;
      OP_SET:   applyOp = cur | val;
      default:  applyOp = cur;
    endcase
  endfunction

endpackage

// File: rtl/prio_intc_decode.sv
module prio_intc_decode
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 48,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        stb
);

  localparam int NumFlagWords = (NUM_SRC + 31) / 32;
  localparam int NumPriWords  = (NUM_SRC + 3) / 4;
  localparam int SlotW        = ADDR_W - 4;

  localparam logic [SlotW-1:0] SlotCtrl    = SlotW'(0);
  localparam logic [SlotW-1:0] SlotStat    = SlotW'(2);
  localparam logic [SlotW-1:0] SlotFlag    = SlotW'(4);
  localparam logic [SlotW-1:0] SlotFlagEnd = SlotW'(4 + NumFlagWords);
  localparam logic [SlotW-1:0] SlotEn      = SlotW'(12);
  localparam logic [SlotW-1:0] SlotEnEnd   = SlotW'(12 + NumFlagWords);
  localparam logic [SlotW-1:0] SlotPri     = SlotW'(20);
  localparam logic [SlotW-1:0] SlotPriEnd  = SlotW'(20 + NumPriWords);
  localparam logic [ADDR_W-1:0] VecBase    = ADDR_W'(32'h540);
  localparam logic [ADDR_W-1:0] VecEnd     = ADDR_W'(32'h540 + 4 * NUM_SRC);

  logic [SlotW-1:0]  slot;
  logic [ADDR_W-1:0] vecOff;

  assign slot   = busAddr[ADDR_W-1:4];
  assign vecOff = busAddr - VecBase;

  always_comb begin
    stb.sel  = SEL_NONE;
    stb.op   = wrOp_e'(busAddr[3:2]);
    stb.idx  = '0;
    stb.wrEn = busWe;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr >= VecBase && busAddr < VecEnd) begin
        stb.sel = SEL_VEC;
        stb.op  = OP_PLAIN;
        stb.idx = IDX_W'(vecOff[ADDR_W-1:2]);
      end else if (busAddr[3:2] != 2'b11) begin
        if (slot == SlotCtrl) begin
          stb.sel = SEL_CTRL;
        end else if (slot == SlotStat) begin
          stb.sel  = SEL_STAT;
          stb.wrEn = 1'b0;
        end else if (slot >= SlotFlag && slot < SlotFlagEnd) begin
          stb.sel = SEL_FLAG;
          stb.idx = IDX_W'(slot - SlotFlag);
        end else if (slot >= SlotEn && slot < SlotEnEnd) begin
          stb.sel = SEL_EN;
          stb.idx = IDX_W'(slot - SlotEn);
        end else if (slot >= SlotPri && slot < SlotPriEnd) begin
          stb.sel = SEL_PRI;
          stb.idx = IDX_W'(slot - SlotPri);
        end
      end
    end
    if (stb.sel == SEL_NONE) stb.wrEn = 1'b0;
  end

endmodule

// File: rtl/prio_intc_datapath.sv
module prio_intc_datapath
  import prio_intc_pkg::*;
#(
  parameter int                 NUM_SRC      = 48,
  parameter int                 NUM_EXT      = 4,
  parameter int                 EXT_BASE     = 8,
  parameter logic [NUM_SRC-1:0] PERSIST_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               stb,
  input  logic [BUS_W-1:0]         busWdata,
  input  logic [NUM_SRC-1:0]       srcReq,
  input  logic [NUM_EXT-1:0]       extPin,
  input  logic [IDX_W-1:0]         winId,
  input  logic                     winValid,
  output logic [BUS_W-1:0]         busRdata,
  output logic [NUM_SRC-1:0]       eligible,
  output logic [NUM_SRC*PRI_W-1:0] priFlat,
  output logic [NUM_SRC-1:0]       flagVec,
  output logic [NUM_SRC-1:0]       enVec,
  output logic [NUM_EXT-1:0]       polVec
);

  localparam int NumFlagWords = (NUM_SRC + 31) / 32;
  localparam int NumPriWords  = (NUM_SRC + 3) / 4;
  localparam int FlagPadW     = NumFlagWords * BUS_W;
  localparam int PriPadW      = NumPriWords * BUS_W;

  logic [NUM_SRC-1:0] flagQ, flagD, enQ, enD, hwSet, reqPrevQ;
  logic [NUM_EXT-1:0] polQ, polD, pinPrevQ;
  logic [PRI_W-1:0]   priQ [NUM_SRC];
  logic [PRI_W-1:0]   priD [NUM_SRC];
  logic [BUS_W-1:0]   vecQ [NUM_SRC];
  logic [BUS_W-1:0]   vecD [NUM_SRC];
  logic [FlagPadW-1:0] flagPad, enPad;
  logic [PriPadW-1:0]  priPad;
  logic                ctrlHit;
  logic                unusedBits;

  assign ctrlHit = stb.wrEn && stb.sel == SEL_CTRL;
  assign polD    = ctrlHit ? NUM_EXT'(applyOp(stb.op, BUS_W'(polQ), busWdata)) : polQ;

  // per-source request detection and register next state
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int WordIdx = n / 32;
    localparam int BitIdx  = n % 32;
    localparam int PriWord = n / 4;
    localparam int LaneLo  = (n % 4) * LANE_W;

    logic flagHit, enHit, priHit, vecHit;
    assign flagHit = stb.wrEn && stb.sel == SEL_FLAG && stb.idx == IDX_W'(WordIdx);
    assign enHit   = stb.wrEn && stb.sel == SEL_EN   && stb.idx == IDX_W'(WordIdx);
    assign priHit  = stb.wrEn && stb.sel == SEL_PRI  && stb.idx == IDX_W'(PriWord);
    assign vecHit  = stb.wrEn && stb.sel == SEL_VEC  && stb.idx == IDX_W'(n);

    if (n >= EXT_BASE && n < EXT_BASE + NUM_EXT) begin : g_ext
      localparam int E = n - EXT_BASE;
      // R10: polarity bit selects which pin edge latches the flag
      assign hwSet[n] = polQ[E] ? (extPin[E] & ~pinPrevQ[E])
                                : (~extPin[E] & pinPrevQ[E]);
    end else if (PERSIST_MASK[n]) begin : g_lvl
      assign hwSet[n] = srcReq[n];                    // R9
    end else begin : g_edge
      assign hwSet[n] = srcReq[n] & ~reqPrevQ[n];     // R8
    end

    assign flagD[n] = (flagHit ? applyOp(stb.op, BUS_W'(flagQ[n]), BUS_W'(busWdata[BitIdx])) != '0
                               : flagQ[n]) | hwSet[n];
    assign enD[n]   = enHit ? applyOp(stb.op, BUS_W'(enQ[n]), BUS_W'(busWdata[BitIdx])) != '0
                            : enQ[n];
    assign priD[n]  = priHit ? PRI_W'(applyOp(stb.op, BUS_W'(priQ[n]),
                                              BUS_W'(busWdata[LaneLo +: PRI_W])))
                             : priQ[n];
    assign vecD[n]  = vecHit ? busWdata : vecQ[n];

    assign eligible[n]                = flagQ[n] & enQ[n] & (priQ[n] != '0);
    assign priFlat[n*PRI_W +: PRI_W]  = priQ[n];
    assign priPad[n*LANE_W +: LANE_W] = LANE_W'(priQ[n]);
  end

  if (NumPriWords * 4 > NUM_SRC) begin : g_priTail
    assign priPad[PriPadW-1:NUM_SRC*LANE_W] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= '0;
      enQ      <= '0;
      polQ     <= '0;
      pinPrevQ <= '0;
      reqPrevQ <= '0;
      for (int n = 0; n < NUM_SRC; n++) begin
        priQ[n] <= DEF_PRI;
        vecQ[n] <= '0;
      end
    end else begin
      flagQ    <= flagD;
      enQ      <= enD;
      polQ     <= polD;
      pinPrevQ <= extPin;
      reqPrevQ <= srcReq;
      for (int n = 0; n < NUM_SRC; n++) begin
        priQ[n] <= priD[n];
        vecQ[n] <= vecD[n];
      end
    end
  end

  assign flagPad = FlagPadW'(flagQ);
  assign enPad   = FlagPadW'(enQ);

  always_comb begin
    busRdata = '0;
    case (stb.sel)
      SEL_CTRL: busRdata = BUS_W'(polQ);
      SEL_STAT: busRdata = BUS_W'({winValid, winId});
      SEL_FLAG: for (int w = 0; w < NumFlagWords; w++)
                  if (stb.idx == IDX_W'(w)) busRdata = flagPad[w*BUS_W +: BUS_W];
      SEL_EN:   for (int w = 0; w < NumFlagWords; w++)
                  if (stb.idx == IDX_W'(w)) busRdata = enPad[w*BUS_W +: BUS_W];
      SEL_PRI:  for (int w = 0; w < NumPriWords; w++)
                  if (stb.idx == IDX_W'(w)) busRdata = priPad[w*BUS_W +: BUS_W];
      SEL_VEC:  for (int n = 0; n < NUM_SRC; n++)
                  if (stb.idx == IDX_W'(n)) busRdata = vecQ[n];
      default:  busRdata = '0;
    endcase
  end

  assign flagVec = flagQ;
  assign enVec   = enQ;
  assign polVec  = polQ;

  // request bits of pin and level sources have no reader
  assign unusedBits = ^{srcReq, reqPrevQ};

endmodule

// File: rtl/prio_intc_arbiter.sv
module prio_intc_arbiter
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 48
) (
  input  logic [NUM_SRC-1:0]       eligible,
  input  logic [NUM_SRC*PRI_W-1:0] priFlat,
  output logic [IDX_W-1:0]         winId,
  output logic                     winValid
);

  logic [PRI_W-1:0] priArr [NUM_SRC];
  logic [PRI_W-1:0] bestPri;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign priArr[i] = priFlat[i*PRI_W +: PRI_W];
  end

  // scan from the top down; ">=" lets a lower index take a tie (R6)
  always_comb begin
    bestPri  = '0;
    winId    = '0;
    winValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && priArr[i] >= bestPri) begin
        bestPri  = priArr[i];
        winId    = IDX_W'(i);
        winValid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int                 NUM_SRC      = 48,
  parameter int                 NUM_EXT      = 4,
  parameter int                 EXT_BASE     = 8,
  parameter int                 ADDR_W       = 12,
  parameter logic [NUM_SRC-1:0] PERSIST_MASK = NUM_SRC'(48'h00FF_0000_00F0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_EXT-1:0] extPin,
  output logic               irqOut
);

  regStrobe_t               stb;
  logic [NUM_SRC-1:0]       eligible, flagVec, enVec;
  logic [NUM_SRC*PRI_W-1:0] priFlat;
  logic [NUM_EXT-1:0]       polVec;
  logic [IDX_W-1:0]         winId;
  logic                     winValid;

  prio_intc_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr), .busWe(busWe), .stb(stb)
  );

  prio_intc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE), .PERSIST_MASK(PERSIST_MASK)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .srcReq(srcReq),
    .extPin(extPin), .winId(winId), .winValid(winValid), .busRdata(busRdata),
    .eligible(eligible), .priFlat(priFlat), .flagVec(flagVec), .enVec(enVec),
    .polVec(polVec)
  );

  prio_intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arbiter (
    .eligible(eligible), .priFlat(priFlat), .winId(winId), .winValid(winValid)
  );

  assign irqOut = winValid;

endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker
  import prio_intc_pkg::*;
#(
  parameter int                 NUM_SRC      = 48,
  parameter int                 NUM_EXT      = 4,
  parameter int                 EXT_BASE     = 8,
  parameter logic [NUM_SRC-1:0] PERSIST_MASK = '0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_SRC-1:0]       srcReq,
  input logic [NUM_EXT-1:0]       extPin,
  input logic [NUM_SRC-1:0]       flagVec,
  input logic [NUM_SRC-1:0]       enVec,
  input logic [NUM_EXT-1:0]       polVec,
  input logic [NUM_SRC*PRI_W-1:0] priFlat,
  input logic [IDX_W-1:0]         winId,
  input logic                     irqOut
);

  logic             armedQ;
  logic [PRI_W-1:0] priArr [NUM_SRC];
  logic [PRI_W-1:0] winPri;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign priArr[i] = priFlat[i*PRI_W +: PRI_W];
  end

  always_comb begin
    winPri = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (winId == IDX_W'(i)) winPri = priArr[i];
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_chk
    if (n >= EXT_BASE && n < EXT_BASE + NUM_EXT) begin : g_ext
      localparam int E = n - EXT_BASE;
      p_ext_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
        (armedQ && polVec[E] && $rose(extPin[E])) |=> flagVec[n]);
      p_ext_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
        (armedQ && !polVec[E] && $fell(extPin[E])) |=> flagVec[n]);
    end else if (PERSIST_MASK[n]) begin : g_lvl
      p_level_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
        srcReq[n] |=> flagVec[n]);
    end else begin : g_edge
      p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
        (armedQ && $rose(srcReq[n])) |=> flagVec[n]);
    end

    // R5: the reported winner qualifies
    p_win_qualifies_r5: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut && winId == IDX_W'(n)) |-> (flagVec[n] && enVec[n] && priArr[n] != '0));
    // R6: no qualifying source outranks the winner
    p_win_best_r6: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut && flagVec[n] && enVec[n] && priArr[n] != '0) |->
        (priArr[n] < winPri || (priArr[n] == winPri && IDX_W'(n) >= winId)));
    // R7: any qualifying source raises the line
    p_irq_raised_r7: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[n] && enVec[n] && priArr[n] != '0) |-> irqOut);
  end

endmodule

bind prio_intc prio_intc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE), .PERSIST_MASK(PERSIST_MASK)
) u_checker (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .extPin(extPin), .flagVec(flagVec),
  .enVec(enVec), .polVec(polVec), .priFlat(priFlat), .winId(winId), .irqOut(irqOut)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;

  localparam int NSRC = 48;
  localparam int NEXT = 4;
  localparam int EBASE = 8;
  localparam logic [NSRC-1:0] PMASK = 48'h00FF_0000_00F0;
  localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h020, A_FLAG = 12'h040;
  localparam logic [11:0] A_EN = 12'h0C0, A_PRI = 12'h140, A_VEC = 12'h540;
  localparam logic [11:0] O_CLR = 12'h004, O_SET = 12'h008;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [11:0]       busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NSRC-1:0]   srcReq = '0;
  logic [NEXT-1:0]   extPin = '0;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  logic [4:0] mPri [NSRC];
  logic       mFlag [NSRC];
  logic       mEn [NSRC];

  always #2 clk = ~clk;

  prio_intc #(.NUM_SRC(NSRC), .NUM_EXT(NEXT), .EXT_BASE(EBASE), .PERSIST_MASK(PMASK))
  i_prio_intc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .srcReq(srcReq), .extPin(extPin), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] expStatus();
    logic [4:0] best = '0;
    logic [7:0] id = '0;
    logic       valid = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (mFlag[i] && mEn[i] && mPri[i] != 0 && mPri[i] > best) begin
        best = mPri[i]; id = 8'(i); valid = 1'b1;
      end
    return {23'd0, valid, id};
  endfunction

  function automatic logic [31:0] priWord(input int w);
    logic [31:0] d = '0;
    for (int l = 0; l < 4; l++) d[l*8 +: 8] = {3'b0, mPri[w*4+l]};
    return d;
  endfunction

  function automatic logic [31:0] bitWord(input int w, input logic useFlag);
    logic [31:0] d = '0;
    for (int b = 0; b < 32; b++)
      if (w*32+b < NSRC) d[b] = useFlag ? mFlag[w*32+b] : mEn[w*32+b];
    return d;
  endfunction

  task automatic clearAll();
    busWrite(A_FLAG + O_CLR, 32'hFFFF_FFFF);
    busWrite(A_FLAG + 12'h010 + O_CLR, 32'hFFFF_FFFF);
    busWrite(A_EN, 32'h0);
    busWrite(A_EN + 12'h010, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] exp;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_CTRL, rd);  chk("R1 ctrl", rd, 32'h0);
    busRead(A_STAT, rd);  chk("R1 status", rd, 32'h0);
    chk("R1 irqOut", 32'(irqOut), 32'h0);
    for (int w = 0; w < 2; w++) begin
      busRead(A_FLAG + 12'(w*16), rd); chk("R1 flag", rd, 32'h0);
      busRead(A_EN + 12'(w*16), rd);   chk("R1 enable", rd, 32'h0);
    end
    for (int w = 0; w < 12; w++) begin
      busRead(A_PRI + 12'(w*16), rd); chk("R1 priority", rd, 32'h0808_0808);
    end

    // R2 / R3 enable bank and aliases
    busWrite(A_EN, 32'hA5A5_0000);
    busRead(A_EN, rd); chk("R2 enable plain", rd, 32'hA5A5_0000);
    busWrite(A_EN + O_CLR, 32'h0500_0000);
    busRead(A_EN + O_CLR, rd); chk("R3 clear alias", rd, 32'hA0A5_0000);
    busWrite(A_EN + O_SET, 32'h0000_0003);
    busRead(A_EN + O_SET, rd); chk("R3 set alias", rd, 32'hA0A5_0003);
    busWrite(A_EN + 12'h010, 32'hFFFF_FFFF);
    busRead(A_EN + 12'h010, rd); chk("R2 upper word width", rd, 32'h0000_FFFF);
    busWrite(A_CTRL + O_SET, 32'h0000_0004);
    busRead(A_CTRL, rd); chk("R3 ctrl set alias", rd, 32'h0000_0004);
    busWrite(A_CTRL + O_CLR, 32'h0000_0004);

    // R4 priority lanes
    busWrite(A_PRI + 12'h030, 32'hFF1F_0A03);
    busRead(A_PRI + 12'h030, rd); chk("R4 lane mask", rd, 32'h1F1F_0A03);
    busWrite(A_PRI + 12'h030 + O_CLR, 32'h0000_0001);
    busRead(A_PRI + 12'h030, rd); chk("R4 lane clear", rd, 32'h1F1F_0A02);

    // R5 R6 R7 random priority / pending / enable patterns
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < NSRC; i++) begin
        case ($urandom % 4)
          0: mPri[i] = 5'd0;
          1: mPri[i] = 5'd8;
          2: mPri[i] = 5'd9;
          default: mPri[i] = 5'd20;
        endcase
        mFlag[i] = ($urandom % 3) == 0;
        mEn[i]   = ($urandom % 2) == 0;
      end
      for (int w = 0; w < 12; w++) busWrite(A_PRI + 12'(w*16), priWord(w));
      for (int w = 0; w < 2; w++) begin
        busWrite(A_FLAG + 12'(w*16), bitWord(w, 1'b1));
        busWrite(A_EN + 12'(w*16), bitWord(w, 1'b0));
      end
      exp = expStatus();
      busRead(A_STAT, rd); chk("R5 R6 status", rd, exp);
      chk("R7 irqOut", 32'(irqOut), 32'(exp[8]));
    end

    // R6 directed tie, R7 zero priority
    clearAll();
    busWrite(A_PRI, 32'h0000_0000);
    busWrite(A_PRI + 12'h0A0, 32'h0000_001C);
    busWrite(A_PRI, 32'h1C00_0000);
    busWrite(A_EN, 32'h0000_0008);
    busWrite(A_EN + 12'h010, 32'h0000_0100);
    busWrite(A_FLAG + O_SET, 32'h0000_0008);
    busWrite(A_FLAG + 12'h010 + O_SET, 32'h0000_0100);
    busRead(A_STAT, rd); chk("R6 tie lower wins", rd, 32'h0000_0103);
    busWrite(A_STAT, 32'h0000_00FF);
    busRead(A_STAT, rd); chk("R5 status write ignored", rd, 32'h0000_0103);
    busWrite(A_PRI, 32'h0);
    busRead(A_STAT, rd); chk("R7 zero pri excluded", rd, 32'h0000_0128);
    busWrite(A_PRI + 12'h0A0, 32'h0);
    busRead(A_STAT, rd); chk("R7 none qualifies", rd, 32'h0);
    chk("R7 irqOut low", 32'(irqOut), 32'h0);

    // R8 edge source 1
    clearAll();
    @(negedge clk) srcReq[1] = 1'b1;
    @(negedge clk) srcReq[1] = 1'b0;
    busRead(A_FLAG, rd); chk("R8 pulse latches", rd & 32'h2, 32'h2);
    repeat (3) @(negedge clk);
    busRead(A_FLAG, rd); chk("R8 flag holds", rd & 32'h2, 32'h2);
    busWrite(A_FLAG + O_CLR, 32'h2);
    @(negedge clk) srcReq[1] = 1'b1;
    busRead(A_FLAG, rd); chk("R8 held request sets", rd & 32'h2, 32'h2);
    busWrite(A_FLAG + O_CLR, 32'h2);
    busRead(A_FLAG, rd); chk("R8 clear under held request", rd & 32'h2, 32'h0);
    @(negedge clk) srcReq[1] = 1'b0;

    // R9 level source 5
    @(negedge clk) srcReq[5] = 1'b1;
    busRead(A_FLAG, rd); chk("R9 level sets", rd & 32'h20, 32'h20);
    busWrite(A_FLAG + O_CLR, 32'h20);
    busRead(A_FLAG, rd); chk("R9 clear overridden", rd & 32'h20, 32'h20);
    @(negedge clk) srcReq[5] = 1'b0;
    busWrite(A_FLAG + O_CLR, 32'h20);
    busRead(A_FLAG, rd); chk("R9 clear after drop", rd & 32'h20, 32'h0);

    // R10 external pin 0 -> source 8
    @(negedge clk) extPin[0] = 1'b1;
    busRead(A_FLAG, rd); chk("R10 rising ignored when falling selected", rd & 32'h100, 32'h0);
    @(negedge clk) extPin[0] = 1'b0;
    busRead(A_FLAG, rd); chk("R10 falling edge", rd & 32'h100, 32'h100);
    busWrite(A_FLAG + O_CLR, 32'h100);
    busWrite(A_CTRL + O_SET, 32'h1);
    @(negedge clk) extPin[0] = 1'b1;
    busRead(A_FLAG, rd); chk("R10 rising edge", rd & 32'h100, 32'h100);
    busWrite(A_FLAG + O_CLR, 32'h100);
    @(negedge clk) extPin[0] = 1'b0;
    busRead(A_FLAG, rd); chk("R10 falling ignored when rising selected", rd & 32'h100, 32'h0);
    @(negedge clk) srcReq[8] = 1'b1;
    repeat (3) @(negedge clk);
    busRead(A_FLAG, rd); chk("R10 request input ignored", rd & 32'h100, 32'h0);
    srcReq[8] = 1'b0;

    // R11 vector offset words
    busWrite(A_VEC, 32'h1234_5678);
    busWrite(A_VEC + 12'(4*47), 32'hDEAD_BEEF);
    busRead(A_VEC, rd); chk("R11 vector first", rd, 32'h1234_5678);
    busRead(A_VEC + 12'(4*47), rd); chk("R11 vector last", rd, 32'hDEAD_BEEF);
    for (int k = 0; k < 6; k++) begin
      int n = int'($urandom % NSRC);
      logic [31:0] v = $urandom;
      if (n == 0 || n == 47) n = 20;
      busWrite(A_VEC + 12'(4*n), v);
      busRead(A_VEC + 12'(4*n), rd); chk("R11 vector random", rd, v);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule